// File: doc/BRIEF.md
# Endpoint Ping-Pong Packet Buffer

This block holds packet data for a single USB endpoint. It sits between a processor, which reaches it through a small register-style port, and a serial interface engine (SIE), which moves packets on the bus. Storage is two halves of `MAXP` bytes each. In single mode the processor and the SIE share one half. In ping-pong mode one half faces the processor and the other faces the SIE, and the two trade roles whenever the processor side is ready and the SIE side is free.

For a transmit endpoint (`cfg_in` = 1), the processor pushes bytes through the data port while `st_valid` is 0. The half is handed on when it reaches `MAXP` bytes or when the processor strobes `ctl_commit`. A commit on a partly filled half sends a short packet. A commit on an empty half sends a zero-length packet. Strobing `ctl_commit` and `ctl_flush` together discards the data and queues a zero-length packet, and `st_valid` then stays high until that packet has gone out.

For a receive endpoint (`cfg_in` = 0), the SIE writes a packet into its half. The processor sees `st_valid` and the byte count, reads the bytes in order, and releases the half with `ctl_flush`. Each role swap or clear raises `st_busy` for `BUSY_CYC` cycles. While `st_busy` is high the data port is locked and the status length reads 0. `cfg_in` and `cfg_pingpong` are changed only together with a `ctl_all_clr` strobe.

Top module: `ep_pingpong_buf`

## Requirements
- R1: After reset, `st_valid` = 0, `st_len` = 0 and `st_busy` = 0. `sie_ready` is 0 for a transmit endpoint and 1 for a receive endpoint.
- R2: Transmit: a data-port write taken while `st_valid` = 0 and `st_busy` = 0 appends one byte and increments `st_len`. The write that brings the count to `MAXP` sets `st_valid`, and the SIE then sees `sie_ready` = 1 with `sie_len` = `MAXP` and the bytes at addresses 0 upward in write order.
- R3: Transmit: a `ctl_commit` strobe without `ctl_flush` on a half holding n < `MAXP` bytes offers an n-byte packet to the SIE. If n = 0, the packet has length 0.
- R4: Transmit: `ctl_commit` and `ctl_flush` in the same strobe drop the bytes written so far and offer a length-0 packet. `st_valid` stays 1 until the SIE completes that packet with `sie_done`, in both modes.
- R5: Transmit, single mode: `st_valid` stays 1 until `sie_done` or a `ctl_sie_clr` or `ctl_all_clr` strobe, and then returns to 0.
- R6: Transmit, ping-pong mode: a committed half moves to the SIE side as soon as that side is free, after which `st_valid` = 0 and the processor can fill the other half. When both halves hold packets, `st_valid` stays 1 until the SIE completes one and the halves swap.
- R7: Transmit: a `ctl_flush` strobe alone while `st_valid` = 0 empties the processor half (`st_len` reads 0) and its bytes are never sent.
- R8: Receive: bytes written with `sie_wr` followed by `sie_end` make `st_valid` = 1 and `st_len` = byte count, and the data port returns the bytes in arrival order, one per `dat_rd`. In single mode `sie_ready` is 0 while the packet is held.
- R9: Receive: `ctl_flush` while `st_valid` = 1 clears `st_valid` and zeroes `st_len`. In ping-pong mode a packet already held on the SIE side then swaps in and is reported.
- R10: Each swap or clear holds `st_busy` = 1 for `BUSY_CYC` cycles. While busy, `dat_rdata` and `st_len` read 0, and `dat_rd` or `dat_wr` strobes are ignored.
- R11: Transmit: data-port writes while `st_valid` = 1 are ignored; neither `st_len` nor the later packet changes.
- R12: A `ctl_flush` strobe alone is ignored on a receive endpoint with `st_valid` = 0 (no busy period starts) and on a single-mode transmit endpoint with `st_valid` = 1 (length and valid unchanged).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in | input | 1 | 1 = transmit (IN) endpoint, 0 = receive (OUT) endpoint |
| cfg_pingpong | input | 1 | 1 = two halves alternate, 0 = single half |
| ctl_wr | input | 1 | Strobe qualifying the four control bits below |
| ctl_commit | input | 1 | Write-one: force packet completion (transmit) |
| ctl_flush | input | 1 | Write-one: empty the processor-side half |
| ctl_sie_clr | input | 1 | Write-one: empty the SIE-side half |
| ctl_all_clr | input | 1 | Write-one: empty both halves and restart |
| dat_wr | input | 1 | Data-port write strobe |
| dat_wdata | input | DW | Data-port write byte |
| dat_rd | input | 1 | Data-port read strobe (advances the read pointer) |
| dat_rdata | output | DW | Current byte at the read pointer, 0 when unavailable |
| st_valid | output | 1 | Processor-side half holds a ready packet |
| st_len | output | LW | Byte count of the processor-side half, 0 while busy |
| st_busy | output | 1 | Swap or clear in progress |
| sie_ready | output | 1 | Transmit: packet waiting; receive: half free to fill |
| sie_len | output | LW | Byte count of the SIE-side half |
| sie_raddr | input | AW | SIE read address into its half |
| sie_rdata | output | DW | SIE read data |
| sie_done | input | 1 | SIE finished sending its packet |
| sie_wr | input | 1 | SIE received-byte strobe |
| sie_wdata | input | DW | SIE received byte |
| sie_end | input | 1 | SIE received packet complete |

## Verification
The in-module assertions watch the rules that hold on every clock edge. Reads during busy never move the read pointer. A single-mode transmit `st_valid` drops only on `sie_done` or a clear. A pending zero-length packet keeps `st_valid` high. A full write sets valid. A receive flush either starts a busy period with valid cleared or, when nothing is held, starts none. The end-to-end properties can only be shown by the bench's scenarios: packet contents and lengths as the SIE sees them, the ordering of two queued packets across a swap, discarded bytes never appearing on the bus, and a held receive packet swapping in after a flush.

// File: rtl/ep_pingpong_buf.sv
`timescale 1ns/1ps
module ep_pingpong_buf #(
  parameter int DW = 8,
  parameter int MAXP = 8,
  parameter int BUSY_CYC = 2,
  localparam int AW = $clog2(MAXP),
  localparam int LW = $clog2(MAXP + 1),
  localparam int BW = $clog2(BUSY_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_in,
  input  logic          cfg_pingpong,
  input  logic          ctl_wr,
  input  logic          ctl_commit,
  input  logic          ctl_flush,
  input  logic          ctl_sie_clr,
  input  logic          ctl_all_clr,
  input  logic          dat_wr,
  input  logic [DW-1:0] dat_wdata,
  input  logic          dat_rd,
  output logic [DW-1:0] dat_rdata,
  output logic          st_valid,
  output logic [LW-1:0] st_len,
  output logic          st_busy,
  output logic          sie_ready,
  output logic [LW-1:0] sie_len,
  input  logic [AW-1:0] sie_raddr,
  output logic [DW-1:0] sie_rdata,
  input  logic          sie_done,
  input  logic          sie_wr,
  input  logic [DW-1:0] sie_wdata,
  input  logic          sie_end
);

  logic [DW-1:0] mem [2][MAXP];
  logic [LW-1:0] cnt [2];
  logic [1:0]    full;
  logic          cb, zlp;
  logic [LW-1:0] rptr;
  logic [BW-1:0] bcnt;

  logic ch, sh, busy, valid;
  logic wa, ws, wv, wb;
  logic in_wr_ok, out_wr_ok, rd_ok, rd_avail;
  logic commit_cmd, zlp_cmd, bclr_in, bclr_out, tx_done, swap, clr_evt;

  assign ch    = cb;
  assign sh    = cfg_pingpong ? ~cb : cb;
  assign busy  = bcnt != '0;
  assign valid = full[ch] | zlp;

  assign wa = ctl_wr & ctl_all_clr;
  assign ws = ctl_wr & ctl_sie_clr;
  assign wv = ctl_wr & ctl_commit;
  assign wb = ctl_wr & ctl_flush;

  assign swap = cfg_pingpong & ~wa &
                (cfg_in ? (full[ch] & ~full[sh]) : (~full[ch] & full[sh]));

  assign in_wr_ok   = cfg_in & dat_wr & ~valid & ~busy & (cnt[ch] != LW'(MAXP)) & ~wa;
  assign out_wr_ok  = ~cfg_in & sie_wr & ~full[sh] & (cnt[sh] != LW'(MAXP)) & ~wa;
  assign rd_avail   = ~cfg_in & full[ch] & ~busy & (rptr < cnt[ch]);
  assign rd_ok      = rd_avail & dat_rd;
  assign commit_cmd = cfg_in & wv & ~wb & ~full[ch];
  assign zlp_cmd    = cfg_in & wv & wb & (cfg_pingpong | ~full[ch]);
  assign bclr_in    = cfg_in & wb & ~wv & (cfg_pingpong | ~valid);
  assign bclr_out   = ~cfg_in & wb & full[ch];
  assign tx_done    = cfg_in & sie_done & full[sh];
  assign clr_evt    = wa | ws | swap | bclr_in | bclr_out | zlp_cmd | tx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb     <= 1'b0;
      full   <= '0;
      cnt[0] <= '0;
      cnt[1] <= '0;
      zlp    <= 1'b0;
      rptr   <= '0;
      bcnt   <= '0;
    end else begin
      if (busy) bcnt <= bcnt - BW'(1);
      if (wa) begin
        cb     <= 1'b0;
        full   <= '0;
        cnt[0] <= '0;
        cnt[1] <= '0;
        zlp    <= 1'b0;
      end else if (swap) begin
        cb <= ~cb;
      end else begin
        if (cfg_in) begin
          if (in_wr_ok) begin
            cnt[ch] <= cnt[ch] + LW'(1);
            if (cnt[ch] == LW'(MAXP - 1)) full[ch] <= 1'b1;
          end
          if (commit_cmd) full[ch] <= 1'b1;
          if (bclr_in) begin
            cnt[ch]  <= '0;
            full[ch] <= 1'b0;
          end
          if (zlp_cmd) begin
            cnt[ch]  <= '0;
            full[ch] <= 1'b1;
            zlp      <= 1'b1;
          end
          if (tx_done) begin
            full[sh] <= 1'b0;
            cnt[sh]  <= '0;
            if (cnt[sh] == '0) zlp <= 1'b0;
          end
        end else begin
          if (out_wr_ok) cnt[sh] <= cnt[sh] + LW'(1);
          if (sie_end && !full[sh]) full[sh] <= 1'b1;
          if (rd_ok) rptr <= rptr + LW'(1);
          if (bclr_out) begin
            full[ch] <= 1'b0;
            cnt[ch]  <= '0;
          end
        end
        if (ws) begin
          full[sh] <= 1'b0;
          cnt[sh]  <= '0;
          zlp      <= 1'b0;
        end
      end
      if (clr_evt) begin
        bcnt <= BW'(BUSY_CYC);
        rptr <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_wr_ok)  mem[ch][cnt[ch][AW-1:0]] <= dat_wdata;
    if (out_wr_ok) mem[sh][cnt[sh][AW-1:0]] <= sie_wdata;
  end

  assign dat_rdata = rd_avail ? mem[ch][rptr[AW-1:0]] : '0;
  assign st_valid  = valid;
  assign st_len    = busy ? '0 : cnt[ch];
  assign st_busy   = busy;
  assign sie_ready = cfg_in ? full[sh] : ~full[sh];
  assign sie_len   = cnt[sh];
  assign sie_rdata = mem[sh][sie_raddr];

  // R10
  busy_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy && dat_rd && !ctl_wr |=> $stable(rptr));

  // R5
  single_tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_in && !cfg_pingpong && st_valid && !sie_done && !ctl_wr |=> st_valid);

  // R4
  zlp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_in && zlp && !sie_done && !ctl_wr |=> st_valid);

  // R2
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wr_ok && !ctl_wr && cnt[ch] == LW'(MAXP - 1) |=> st_valid || st_busy);

  // R9
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_in && ctl_wr && ctl_flush && !ctl_all_clr && st_valid |=> !st_valid && st_busy);

  // R12
  rx_flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_in && ctl_wr && ctl_flush && !ctl_sie_clr && !ctl_all_clr && !st_valid && !st_busy && !swap
    |=> !st_busy);

endmodule

// File: tb/sim_ep_pingpong_buf.sv
`timescale 1ns/1ps
module sim_ep_pingpong_buf;
  localparam int DW = 8, MAXP = 8, AW = 3, LW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_in = 1, cfg_pingpong = 0;
  logic ctl_wr = 0, ctl_commit = 0, ctl_flush = 0, ctl_sie_clr = 0, ctl_all_clr = 0;
  logic dat_wr = 0, dat_rd = 0;
  logic [DW-1:0] dat_wdata = 0, sie_wdata = 0;
  logic [DW-1:0] dat_rdata, sie_rdata;
  logic st_valid, st_busy, sie_ready;
  logic [LW-1:0] st_len, sie_len;
  logic [AW-1:0] sie_raddr;
  logic sie_done, sie_wr = 0, sie_end = 0;
  logic sie_auto = 0;

  int n_chk = 0, n_fail = 0;
  int len_q[$];
  int byte_q[$];

  always #2 clk = ~clk;

  ep_pingpong_buf #(.DW(DW), .MAXP(MAXP), .BUSY_CYC(2)) u0 (
    .clk, .rst_n, .cfg_in, .cfg_pingpong, .ctl_wr, .ctl_commit, .ctl_flush,
    .ctl_sie_clr, .ctl_all_clr, .dat_wr, .dat_wdata, .dat_rd, .dat_rdata,
    .st_valid, .st_len, .st_busy, .sie_ready, .sie_len, .sie_raddr, .sie_rdata,
    .sie_done, .sie_wr, .sie_wdata, .sie_end);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_pkt(input int n, input int base);
    len_q.push_back(n);
    for (int i = 0; i < n; i++) byte_q.push_back((base + i) & 8'hff);
  endtask

  task automatic cpu_write(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dat_wr = 1; dat_wdata = DW'(base + i);
    end
    @(negedge clk); dat_wr = 0;
  endtask

  task automatic ctl(input bit v, input bit b, input bit s, input bit a);
    @(negedge clk);
    ctl_wr = 1; ctl_commit = v; ctl_flush = b; ctl_sie_clr = s; ctl_all_clr = a;
    @(negedge clk);
    ctl_wr = 0; ctl_commit = 0; ctl_flush = 0; ctl_sie_clr = 0; ctl_all_clr = 0;
  endtask

  task automatic wait_quiet();
    repeat (2) @(negedge clk);
    while (st_busy) @(negedge clk);
  endtask

  task automatic wait_sent();
    while (len_q.size() != 0) @(negedge clk);
    wait_quiet();
  endtask

  task automatic sie_send(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sie_wr = 1; sie_wdata = DW'(base + i);
    end
    @(negedge clk); sie_wr = 0; sie_end = 1;
    @(negedge clk); sie_end = 0;
  endtask

  task automatic cpu_read(input int n, input int base, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(dat_rdata == DW'(base + i), req, "read byte", dat_rdata, (base + i) & 8'hff);
      dat_rd = 1;
    end
    @(negedge clk); dat_rd = 0;
  endtask

  // SIE-side scoreboard monitor for transmit packets
  initial begin
    sie_done = 0; sie_raddr = 0;
    forever begin
      @(negedge clk);
      sie_done = 0;
      if (sie_auto && cfg_in && sie_ready) begin
        if (len_q.size() == 0) chk(0, "R2", "unexpected packet", sie_len, -1);
        else begin
          int l;
          l = len_q.pop_front();
          chk(sie_len == LW'(l), "R3", "packet length", sie_len, l);
          for (int i = 0; i < l; i++) begin
            int e;
            sie_raddr = AW'(i);
            #0.1;
            e = byte_q.pop_front();
            chk(sie_rdata == DW'(e), "R2", "packet byte", sie_rdata, e);
          end
          sie_done = 1;
        end
      end
    end
  end

  bit finished = 0;
  initial begin
    #(4 * 150000);
    if (!finished) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(st_valid == 0, "R1", "valid after reset", st_valid, 0);
    chk(st_len == 0, "R1", "len after reset", st_len, 0);
    chk(st_busy == 0, "R1", "busy after reset", st_busy, 0);
    chk(sie_ready == 0, "R1", "tx sie_ready after reset", sie_ready, 0);

    // R2 full packet, single mode
    sie_auto = 1;
    push_pkt(8, 8'h10);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); dat_wr = 1; dat_wdata = DW'(8'h10 + i);
    end
    @(negedge clk); dat_wr = 0;
    chk(st_valid == 1, "R2", "valid after full", st_valid, 1);
    wait_sent();
    chk(st_valid == 0, "R5", "valid after sie_done", st_valid, 0);
    chk(st_len == 0, "R5", "len after send", st_len, 0);

    // R3 short packet and forced zero-length
    push_pkt(3, 8'h20);
    cpu_write(3, 8'h20);
    chk(st_len == 3, "R2", "len after 3 writes", st_len, 3);
    ctl(1, 0, 0, 0);
    wait_sent();
    push_pkt(0, 0);
    ctl(1, 0, 0, 0);
    wait_sent();
    chk(st_valid == 0, "R3", "valid after zlp", st_valid, 0);

    // R11 and R12: writes and flush ignored while valid, single mode
    sie_auto = 0;
    push_pkt(2, 8'h30);
    cpu_write(2, 8'h30);
    ctl(1, 0, 0, 0);
    cpu_write(3, 8'h80);
    chk(st_len == 2, "R11", "len unchanged by writes", st_len, 2);
    ctl(0, 1, 0, 0);
    chk(st_busy == 0, "R12", "no busy from ignored flush", st_busy, 0);
    chk(st_len == 2, "R12", "len unchanged by flush", st_len, 2);
    chk(st_valid == 1, "R12", "valid unchanged by flush", st_valid, 1);
    sie_auto = 1;
    wait_sent();

    // R4 commit+flush -> zero-length packet, valid held
    sie_auto = 0;
    cpu_write(4, 8'h40);
    ctl(1, 1, 0, 0);
    push_pkt(0, 0);
    repeat (5) @(negedge clk);
    chk(st_valid == 1, "R4", "valid held for zlp", st_valid, 1);
    chk(st_len == 0, "R4", "zlp len", st_len, 0);
    chk(sie_len == 0, "R4", "sie zlp len", sie_len, 0);
    sie_auto = 1;
    wait_sent();
    chk(st_valid == 0, "R4", "valid after zlp sent", st_valid, 0);

    // R7 flush while not valid
    cpu_write(5, 8'h50);
    ctl(0, 1, 0, 0);
    wait_quiet();
    chk(st_len == 0, "R7", "len after flush", st_len, 0);
    push_pkt(2, 8'h58);
    cpu_write(2, 8'h58);
    ctl(1, 0, 0, 0);
    wait_sent();

    // R5 SIE-side clear
    sie_auto = 0;
    cpu_write(3, 8'h60);
    ctl(1, 0, 0, 0);
    ctl(0, 0, 1, 0);
    wait_quiet();
    chk(st_valid == 0, "R5", "valid after sie clear", st_valid, 0);
    chk(sie_ready == 0, "R5", "sie_ready after sie clear", sie_ready, 0);

    // R6 ping-pong transmit
    @(negedge clk); cfg_pingpong = 1;
    ctl(0, 0, 0, 1);
    wait_quiet();
    push_pkt(4, 8'h70);
    cpu_write(4, 8'h70);
    ctl(1, 0, 0, 0);
    wait_quiet();
    chk(st_valid == 0, "R6", "valid after swap", st_valid, 0);
    chk(sie_ready == 1, "R6", "sie has packet", sie_ready, 1);
    chk(sie_len == 4, "R6", "sie_len after swap", sie_len, 4);
    push_pkt(3, 8'h90);
    cpu_write(3, 8'h90);
    ctl(1, 0, 0, 0);
    wait_quiet();
    chk(st_valid == 1, "R6", "valid with both halves full", st_valid, 1);
    chk(st_len == 3, "R6", "cpu half len", st_len, 3);
    sie_auto = 1;
    wait_sent();
    chk(st_valid == 0, "R6", "valid after both sent", st_valid, 0);

    // R4 ping-pong zero-length hold
    sie_auto = 0;
    cpu_write(2, 8'hA0);
    ctl(1, 1, 0, 0);
    wait_quiet();
    chk(st_valid == 1, "R4", "pingpong zlp valid held", st_valid, 1);
    push_pkt(0, 0);
    sie_auto = 1;
    wait_sent();
    chk(st_valid == 0, "R4", "pingpong valid after zlp", st_valid, 0);
    sie_auto = 0;

    // Receive, single mode
    @(negedge clk); cfg_in = 0; cfg_pingpong = 0;
    ctl(0, 0, 0, 1);
    wait_quiet();
    chk(sie_ready == 1, "R1", "rx sie_ready idle", sie_ready, 1);
    ctl(0, 1, 0, 0);
    chk(st_busy == 0, "R12", "rx flush on empty ignored", st_busy, 0);
    sie_send(4, 8'hB0);
    chk(st_valid == 1, "R8", "rx valid", st_valid, 1);
    chk(st_len == 4, "R8", "rx len", st_len, 4);
    chk(sie_ready == 0, "R8", "rx sie_ready while held", sie_ready, 0);
    cpu_read(4, 8'hB0, "R8");
    ctl(0, 1, 0, 0);
    chk(st_busy == 1, "R10", "busy after flush", st_busy, 1);
    wait_quiet();
    chk(st_valid == 0, "R9", "rx valid after flush", st_valid, 0);
    chk(st_len == 0, "R9", "rx len after flush", st_len, 0);
    chk(sie_ready == 1, "R9", "rx sie_ready after flush", sie_ready, 1);

    // Receive, ping-pong mode
    @(negedge clk); cfg_pingpong = 1;
    ctl(0, 0, 0, 1);
    wait_quiet();
    sie_send(3, 8'hC0);
    @(negedge clk);
    chk(st_busy == 1, "R10", "busy during swap", st_busy, 1);
    chk(st_len == 0, "R10", "len reads 0 while busy", st_len, 0);
    chk(dat_rdata == 0, "R10", "data reads 0 while busy", dat_rdata, 0);
    dat_rd = 1;
    @(negedge clk); dat_rd = 0;
    while (st_busy) @(negedge clk);
    chk(st_valid == 1, "R8", "pingpong rx valid", st_valid, 1);
    chk(st_len == 3, "R8", "pingpong rx len", st_len, 3);
    cpu_read(3, 8'hC0, "R10");
    chk(sie_ready == 1, "R9", "sie half free", sie_ready, 1);
    sie_send(2, 8'hD0);
    chk(st_len == 3, "R9", "cpu half len kept", st_len, 3);
    ctl(0, 1, 0, 0);
    wait_quiet();
    chk(st_valid == 1, "R9", "next packet swapped in", st_valid, 1);
    chk(st_len == 2, "R9", "next packet len", st_len, 2);
    cpu_read(2, 8'hD0, "R9");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule